// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Condition Flags

This block is the add/subtract slice of an integer execution stage. Each cycle with `valid_i` high it takes a destination operand, a source operand (optionally a sign-extended 8-bit immediate), the incoming carry flag, an operation code and an operand size of 8, 16 or 32 bits. It registers the result, a result write-enable, the six arithmetic condition flags and a mask that tells the flag register which of those flags to overwrite. Exchange-add also returns the old destination value on a second output with its own write-enable.

The operations are add, add-with-carry, subtract, subtract-with-borrow, increment, decrement, negate, compare and exchange-add. Each one has its own flag policy. Increment and decrement leave the carry flag alone. Negate derives carry from a zero test. Compare updates flags but writes nothing back. Operand fetch, memory access and decode happen upstream.

Operation codes on `op_i`: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 increment, 5 decrement, 6 negate, 7 compare, 8 exchange-add, 9 to 15 undefined. Size codes on `size_i`: 0 byte, 1 half-word (16), 2 or 3 word (32).

Top module: `int_addsub_unit`

## Requirements
- R1: Add gives dst+src and add-with-carry gives dst+src+carry_i, truncated to the size. Carry (flags_o bit 0) is the unsigned carry out of the top bit of the size.
- R2: Subtract gives dst−src and subtract-with-borrow gives dst−src−carry_i. With carry_i=0 both give the same result as plain subtract.
- R3: Increment adds 1 and decrement subtracts 1. For both, mask_o bit 0 is 0, flags_o bit 0 equals carry_i, and every other flag follows add/subtract of 1.
- R4: For subtract, subtract-with-borrow and compare, carry is 1 exactly when an unsigned borrow occurs (dst < src for subtract and compare).
- R5: Compare computes dst−src flags with we_o=0 and mask_o=6'h3f.
- R6: After subtract or compare, sign XOR overflow (flags_o bit 2 XOR bit 3) is 1 exactly when dst < src as signed values of the size.
- R7: Negate gives 0−dst. Carry is 0 only for a zero operand. The most negative value of the size comes back unchanged and sets overflow.
- R8: Exchange-add writes dst+src with add flags and drives the size-masked original dst on old_o, with old_we_o=1. Every other operation drives old_o=0 and old_we_o=0.
- R9: With imm8_i=1, src_i[7:0] is sign-extended to the operation size and src_i[31:8] is ignored.
- R10: Overflow (flags_o bit 3) is 1 exactly when the signed result at the operation size is out of range.
- R11: Auxiliary carry (flags_o bit 4) is the carry or borrow at bit 3. Parity (flags_o bit 5) is 1 when res_o[7:0] has an even number of ones.
- R12: Zero (bit 1) and sign (bit 2) refer to the sized result. Bits of res_o above the size are 0, and operand bits above the size are ignored.
- R13: Outputs are registered one cycle after valid_i. Reset drives every output to 0. An undefined op code gives we_o=0, old_we_o=0, mask_o=0 and zero res_o, old_o and flags_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size code |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Source operand |
| imm8_i | input | 1 | Treat src_i[7:0] as a sign-extended immediate |
| carry_i | input | 1 | Incoming carry flag |
| valid_o | output | 1 | Registered result valid |
| res_o | output | 32 | Result, zero above the size |
| we_o | output | 1 | Result write-enable |
| old_o | output | 32 | Original destination (exchange-add) |
| old_we_o | output | 1 | Write-enable for old_o |
| flags_o | output | 6 | {parity, aux, overflow, sign, zero, carry} |
| mask_o | output | 6 | Flag update mask, same bit order |

## Verification
The assertions check on every cycle that increment and decrement never claim the carry flag and pass the old carry through. They also check that compare never asserts a write-enable, that the 32-bit borrow and signed less-than relations hold on the flags, that exchange-add returns the old destination, and that undefined codes produce no write. Only the bench scenarios can show the exact results and the remaining flags at every size. These include the sized overflow and auxiliary carry, the parity of the low byte, immediate sign extension, the negate corner values, and the ignored upper operand bits. The bench shows them by comparing each registered output against a width-aware reference model.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int WORD_W = 32;
  localparam int FLAG_N = 6;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_NEG  = 4'd6,
    OP_CMP  = 4'd7,
    OP_XADD = 4'd8
  } op_e;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;

  typedef struct packed {
    logic pf;
    logic af;
    logic of;
    logic sf;
    logic zf;
    logic cf;
  } flags_t;

  function automatic logic [WORD_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_B:    size_mask = WORD_W'(8'hff);
      SZ_H:    size_mask = WORD_W'(16'hffff);
      default: size_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/ias_operand_sel.sv
module ias_operand_sel
  import addsub_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] dst_i,
  input  logic [DW-1:0] src_i,
  input  logic          imm8_i,
  input  logic          carry_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic          cin_o,
  output logic          is_sub_o,
  output logic          legal_o,
  output logic          we_o,
  output logic          old_we_o,
  output logic          keep_cf_o
);
  logic [DW-1:0] src_e;

  assign src_e = imm8_i ? {{(DW-8){src_i[7]}}, src_i[7:0]} : src_i;

  always_comb begin
    a_o       = dst_i;
    b_o       = src_e;
    cin_o     = 1'b0;
    is_sub_o  = 1'b0;
    legal_o   = 1'b1;
    we_o      = 1'b1;
    old_we_o  = 1'b0;
    keep_cf_o = 1'b0;
    case (op_i)
      OP_ADD: ;
      OP_ADC: cin_o = carry_i;
      OP_SUB: begin
        b_o = ~src_e; cin_o = 1'b1; is_sub_o = 1'b1;
      end
      OP_SBB: begin
        // a + ~b + ~c == a - b - c
        b_o = ~src_e; cin_o = ~carry_i; is_sub_o = 1'b1;
      end
      OP_INC: begin
        b_o = DW'(1); keep_cf_o = 1'b1;
      end
      OP_DEC: begin
        b_o = ~DW'(1); cin_o = 1'b1; is_sub_o = 1'b1; keep_cf_o = 1'b1;
      end
      OP_NEG: begin
        a_o = '0; b_o = ~dst_i; cin_o = 1'b1; is_sub_o = 1'b1;
      end
      OP_CMP: begin
        b_o = ~src_e; cin_o = 1'b1; is_sub_o = 1'b1; we_o = 1'b0;
      end
      OP_XADD: old_we_o = 1'b1;
      default: begin
        legal_o = 1'b0; we_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ias_adder.sv
module ias_adder
  import addsub_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          is_sub_i,
  input  logic [1:0]    size_i,
  output logic [DW-1:0] res_o,
  output logic          cf_o,
  output logic          af_o,
  output logic          of_o
);
  logic [DW-1:0] m, am, bm;
  logic [DW:0]   sum;
  logic          cw, c4, sa, sb, sr;

  always_comb begin
    m   = size_mask(size_i);
    am  = a_i & m;
    bm  = b_i & m;
    sum = {1'b0, am} + {1'b0, bm} + {{DW{1'b0}}, cin_i};
    res_o = sum[DW-1:0] & m;
    case (size_i)
      SZ_B: begin
        cw = sum[8];  sa = am[7];  sb = bm[7];  sr = sum[7];
      end
      SZ_H: begin
        cw = sum[16]; sa = am[15]; sb = bm[15]; sr = sum[15];
      end
      default: begin
        cw = sum[DW]; sa = am[DW-1]; sb = bm[DW-1]; sr = sum[DW-1];
      end
    endcase
    c4   = am[4] ^ bm[4] ^ sum[4];
    // subtraction runs as a + ~b + 1: carry out high means no borrow
    cf_o = is_sub_i ^ cw;
    af_o = is_sub_i ^ c4;
    of_o = (sa == sb) && (sr != sa);
  end
endmodule

// File: rtl/ias_result_flags.sv
module ias_result_flags
  import addsub_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  logic [DW-1:0] res_i,
  input  logic [1:0]    size_i,
  output logic          zf_o,
  output logic          sf_o,
  output logic          pf_o
);
  always_comb begin
    zf_o = (res_i == '0);
    case (size_i)
      SZ_B:    sf_o = res_i[7];
      SZ_H:    sf_o = res_i[15];
      default: sf_o = res_i[DW-1];
    endcase
    pf_o = ~^res_i[7:0];
  end
endmodule

// File: rtl/int_addsub_unit.sv
module int_addsub_unit
  import addsub_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int FN = FLAG_N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] dst_i,
  input  logic [DW-1:0] src_i,
  input  logic          imm8_i,
  input  logic          carry_i,
  output logic          valid_o,
  output logic [DW-1:0] res_o,
  output logic          we_o,
  output logic [DW-1:0] old_o,
  output logic          old_we_o,
  output logic [FN-1:0] flags_o,
  output logic [FN-1:0] mask_o
);
  logic [DW-1:0] a, b, sum_res;
  logic          cin, is_sub, legal, we_d, old_we_d, keep_cf;
  logic          cf, af, of, zf, sf, pf;
  flags_t        fl_d;
  logic [DW-1:0] res_d, old_d;
  logic [FN-1:0] mask_d;

  ias_operand_sel #(.DW(DW)) u_sel (
    .op_i(op_i), .dst_i(dst_i), .src_i(src_i), .imm8_i(imm8_i),
    .carry_i(carry_i), .a_o(a), .b_o(b), .cin_o(cin), .is_sub_o(is_sub),
    .legal_o(legal), .we_o(we_d), .old_we_o(old_we_d), .keep_cf_o(keep_cf)
  );

  ias_adder #(.DW(DW)) u_add (
    .a_i(a), .b_i(b), .cin_i(cin), .is_sub_i(is_sub), .size_i(size_i),
    .res_o(sum_res), .cf_o(cf), .af_o(af), .of_o(of)
  );

  ias_result_flags #(.DW(DW)) u_flg (
    .res_i(sum_res), .size_i(size_i), .zf_o(zf), .sf_o(sf), .pf_o(pf)
  );

  always_comb begin
    fl_d.pf = pf;
    fl_d.af = af;
    fl_d.of = of;
    fl_d.sf = sf;
    fl_d.zf = zf;
    fl_d.cf = keep_cf ? carry_i : cf;
    if (!legal) fl_d = '0;
    res_d  = legal ? sum_res : '0;
    old_d  = old_we_d ? (dst_i & size_mask(size_i)) : '0;
    mask_d = !legal ? '0 : (keep_cf ? {{(FN-1){1'b1}}, 1'b0} : '1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      res_o    <= '0;
      we_o     <= 1'b0;
      old_o    <= '0;
      old_we_o <= 1'b0;
      flags_o  <= '0;
      mask_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o    <= res_d;
        we_o     <= we_d;
        old_o    <= old_d;
        old_we_o <= old_we_d;
        flags_o  <= fl_d;
        mask_o   <= mask_d;
      end else begin
        we_o     <= 1'b0;
        old_we_o <= 1'b0;
        mask_o   <= '0;
      end
    end
  end

  AST_CMP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CMP |=> !we_o && mask_o == '1); // R5
  AST_INCDEC_KEEP_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_INC || op_i == OP_DEC)
    |=> !mask_o[0] && flags_o[0] == $past(carry_i)); // R3
  AST_NEG_MIN_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_NEG && size_i == SZ_B && dst_i[7:0] == 8'h80
    |=> res_o == DW'(8'h80) && flags_o[3] && flags_o[0]); // R7
  AST_BORROW_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_SUB || op_i == OP_CMP) && size_i == SZ_W && !imm8_i
    |=> flags_o[0] == ($past(dst_i) < $past(src_i))); // R4
  AST_SIGNED_LT_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CMP && size_i == SZ_W && !imm8_i
    |=> (flags_o[2] ^ flags_o[3]) == ($signed($past(dst_i)) < $signed($past(src_i)))); // R6
  AST_XADD_OLD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_XADD && size_i == SZ_W
    |=> we_o && old_we_o && old_o == $past(dst_i)); // R8
  AST_UNDEF_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i > 4'd8 |=> !we_o && !old_we_o && mask_o == '0); // R13
endmodule

// File: tb/sim_int_addsub_unit.sv
module sim_int_addsub_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  size = '0;
  logic [31:0] dst = '0, src = '0;
  logic        imm8 = 1'b0, cin = 1'b0;
  logic        valid_o, we_o, old_we_o;
  logic [31:0] res_o, old_o;
  logic [5:0]  flags_o, mask_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  int_addsub_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .size_i(size),
    .dst_i(dst), .src_i(src), .imm8_i(imm8), .carry_i(cin),
    .valid_o(valid_o), .res_o(res_o), .we_o(we_o), .old_o(old_o),
    .old_we_o(old_we_o), .flags_o(flags_o), .mask_o(mask_o)
  );

  // {res, old, we, old_we, mask, flags}
  function automatic logic [77:0] model(input logic [3:0] o, input logic [1:0] sz,
      input logic [31:0] d, input logic [31:0] s, input logic im, input logic c);
    int w;
    longint one, m, half, av, sv, ca, sa, ss, r, sr;
    logic add_p, cf, af, of, zf, sf, pf, we, owe;
    logic [31:0] sx, res, old;
    logic [5:0] mask;
    if (o > 4'd8) return '0;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    one = 1; m = (one << w) - 1; half = one << (w - 1);
    sx = im ? {{24{s[7]}}, s[7:0]} : s;
    av = longint'(d) & m; sv = longint'(sx) & m; ca = 0;
    add_p = 1; we = 1; owe = 0; mask = 6'h3f;
    case (o)
      4'd1: ca = c;
      4'd2: add_p = 0;
      4'd3: begin add_p = 0; ca = c; end
      4'd4: begin sv = 1; mask = 6'h3e; end
      4'd5: begin sv = 1; add_p = 0; mask = 6'h3e; end
      4'd6: begin sv = av; av = 0; add_p = 0; end
      4'd7: begin add_p = 0; we = 0; end
      4'd8: owe = 1;
      default: ;
    endcase
    sa = (av >= half) ? av - (one << w) : av;
    ss = (sv >= half) ? sv - (one << w) : sv;
    if (add_p) begin
      r = av + sv + ca; sr = sa + ss + ca;
      cf = r > m; af = ((av & 15) + (sv & 15) + ca) > 15;
    end else begin
      r = av - sv - ca; sr = sa - ss - ca;
      cf = r < 0; af = ((av & 15) - (sv & 15) - ca) < 0;
    end
    if (o == 4'd4 || o == 4'd5) cf = c;
    res = 32'(r & m);
    of = (sr >= half) || (sr < -half);
    zf = (res == 0);
    sf = res[w-1];
    pf = ~^res[7:0];
    old = owe ? 32'(av) : 32'd0;
    return {res, old, we, owe, mask, pf, af, of, sf, zf, cf};
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R1";
      4'd2, 4'd3: return "R2";
      4'd4, 4'd5: return "R3";
      4'd6:       return "R7";
      4'd7:       return "R5";
      4'd8:       return "R8";
      default:    return "R13";
    endcase
  endfunction

  task automatic run(input string tag, input logic [3:0] o, input logic [1:0] sz,
      input logic [31:0] d, input logic [31:0] s, input logic im, input logic c);
    logic [77:0] exp, got;
    @(negedge clk);
    valid = 1; op = o; size = sz; dst = d; src = s; imm8 = im; cin = c;
    exp = model(o, sz, d, s, im, c);
    @(negedge clk);
    got = {res_o, old_o, we_o, old_we_o, mask_o, flags_o};
    total++;
    if (got !== exp || valid_o !== 1'b1) begin
      bad++;
      $display("FAIL %s op=%0d sz=%0d d=%h s=%h: actual=%h expected=%h", tag, o, sz, d, s, got, exp);
    end
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      bad++; total++;
      $display("FAIL R13 watchdog expired: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] ro;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    total++;  // R13 reset state
    if ({valid_o, res_o, we_o, old_o, old_we_o, flags_o, mask_o} !== '0) begin
      bad++;
      $display("FAIL R13 reset: actual=%h expected=0",
               {valid_o, res_o, we_o, old_o, old_we_o, flags_o, mask_o});
    end
    rst_n = 1;

    run("R1",  4'd1, 2'd0, 32'h0000_00ff, 32'h0000_0000, 0, 1);
    run("R2",  4'd3, 2'd1, 32'h0000_0000, 32'h0000_0000, 0, 1);
    run("R3",  4'd4, 2'd0, 32'h0000_00ff, 32'h0, 0, 0);
    run("R3",  4'd5, 2'd1, 32'h0000_0000, 32'h0, 0, 1);
    run("R4",  4'd7, 2'd2, 32'd5, 32'd7, 0, 0);
    run("R6",  4'd7, 2'd1, 32'h0000_8000, 32'h0000_0001, 0, 0);
    run("R6",  4'd7, 2'd1, 32'h0000_7fff, 32'h0000_ffff, 0, 0);
    run("R7",  4'd6, 2'd0, 32'h0000_0080, 32'h0, 0, 0);
    run("R7",  4'd6, 2'd2, 32'h8000_0000, 32'h0, 0, 0);
    run("R7",  4'd6, 2'd1, 32'h0000_0000, 32'h0, 0, 1);
    run("R8",  4'd8, 2'd1, 32'hdead_1234, 32'h0000_0010, 0, 0);
    run("R9",  4'd0, 2'd2, 32'h0000_0010, 32'h1234_56ff, 1, 0);
    run("R9",  4'd2, 2'd1, 32'h0000_0010, 32'hffff_ff7f, 1, 0);
    run("R10", 4'd0, 2'd0, 32'h0000_007f, 32'h0000_0001, 0, 0);
    run("R11", 4'd0, 2'd0, 32'h0000_000f, 32'h0000_0001, 0, 0);
    run("R11", 4'd2, 2'd0, 32'h0000_0010, 32'h0000_0001, 0, 0);
    run("R12", 4'd0, 2'd1, 32'habcd_ffff, 32'h9876_0001, 0, 0);
    run("R13", 4'd12, 2'd2, 32'h1, 32'h2, 0, 1);

    for (int i = 0; i < 400; i++) begin
      ro = ($urandom_range(0, 9) == 9) ? 4'($urandom_range(9, 15)) : 4'($urandom_range(0, 8));
      run(tag_of(ro), ro, 2'($urandom_range(0, 3)), $urandom, $urandom,
          ($urandom_range(0, 3) == 0), 1'($urandom));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule